// File: doc/BRIEF.md
# Multiphase Rail Fault Sequencer

This block guards a multiphase supply rail. Each power phase has two digital fault flags, one for overcurrent and one for overtemperature. The supply has two undervoltage comparator outputs: one says the input is below the turn-off level, the other says it is above the turn-on level. Every flag passes through its own debounce filter. A confirmed fault is then classified, and the block takes one of two actions. It shuts off only the offending phase, or it inhibits the whole rail. The fault and power-good reports follow in a fixed order. After the fault clears, the block waits out a recovery policy before it drives the rail again.

Only a single new phase fault can be isolated. Isolation must also be enabled, and enough healthy phases must remain to carry the load. Every other case takes the safe global action: undervoltage, several phases at once, isolation disabled, or too few survivors. An auto-retry comes only after a cooldown. Retries are counted, and the count is forgotten once an observation window passes with no new fault. One retry beyond the cap locks the rail off until an explicit clear. In lock mode, every fault locks the rail off at once. All timer lengths are configuration inputs counted in clock cycles.

Top module: `rail_guard`

## Requirements
- R1: A fault flag acts only after it has been sampled high on `deb_len` consecutive clock edges (`deb_len` >= 1). A shorter pulse changes no output.
- R2: A single new phase fault is isolated under three conditions: `iso_en` is 1, `lock_mode` is 0, and the phases left unisolated after it number at least `min_ph`. Isolation sets only that phase's bit of `phase_off`. `rail_off` stays 0, `pgood` stays 1, and the isolated bit stays set until `clear`.
- R3: Confirmed undervoltage (`uv_low`) inhibits the whole rail. So do two or more new phase faults at once, and a single phase fault that cannot be isolated. In each case `rail_off` is 1 and `phase_off` is all ones.
- R4: Inhibit rises in the same cycle a fault is confirmed. `fault` rises, and `pgood` falls, on the next clock edge.
- R5: With `lock_mode` = 1, any confirmed fault sets `locked` and holds `rail_off` at 1, with no retry. Only a one-cycle `clear` releases it.
- R6: After a global fault has cleared, the rail stays off for at least `cool_len` cycles before `rail_off` returns to 0.
- R7: Global faults that occur while `retry_cap` retries are already counted lock the rail instead of retrying.
- R8: The retry count returns to zero once `win_len` cycles pass with no new global fault. After that, the full number of retries is available again.
- R9: Leaving an undervoltage needs `uv_high` = 1 and `uv_low` = 0 for `uv_len` consecutive cycles, and the cooldown follows. While the rail runs, a supply between the two thresholds causes no action.
- R10: `pgood` rises exactly `pg_len`+1 clock edges after `rail_off` falls, and is 0 whenever `rail_off` was 1 on the previous edge.
- R11: `hot` is 1 from one cycle after any phase overtemperature flag is confirmed, and falls after that flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_flag | input | NPH | Per-phase overcurrent flags |
| ot_flag | input | NPH | Per-phase overtemperature flags |
| uv_low | input | 1 | Supply below the turn-off threshold |
| uv_high | input | 1 | Supply above the turn-on threshold |
| lock_mode | input | 1 | 1: every fault locks the rail off |
| iso_en | input | 1 | 1: single-phase isolation allowed |
| min_ph | input | PW | Minimum phases that must remain after isolation |
| deb_len | input | TW | Debounce length in cycles (>= 1) |
| cool_len | input | TW | Cooldown before retry |
| win_len | input | TW | Retry observation window |
| pg_len | input | TW | Power-good stability window |
| uv_len | input | TW | Supply stability window |
| retry_cap | input | CW | Retries allowed inside the window |
| clear | input | 1 | Releases lock and isolated phases |
| phase_off | output | NPH | Per-phase inhibit |
| rail_off | output | 1 | Whole-rail inhibit |
| fault | output | 1 | Fault report |
| pgood | output | 1 | Power good |
| hot | output | 1 | Overtemperature report |
| locked | output | 1 | Rail latched off |

## Verification
The assertions check several rules on every cycle: the undervoltage-to-inhibit latency bound, `fault` never rising without an inhibit in the previous cycle, `pgood` dropping after any rail inhibit, a lock holding until `clear`, and the limit on how many phases may be isolated while the rail runs. Other behaviour needs a history of events, so only the bench scenarios can show it. This covers the cooldown and supply-stability durations, the exact power-good delay, the retry count reaching its cap, and that count being forgotten after a quiet window. The bench also covers the choice between isolation and global shutdown, and glitch rejection.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_COOL = 2'd2,
    ST_LOCK = 2'd3
  } rg_state_e;
endpackage

// File: rtl/rg_filter.sv
// Consecutive-sample debounce: conf rises after len high samples.
module rg_filter #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw,
  input  logic [TW-1:0] len,
  output logic          conf
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !raw) begin
      cnt  <= '0;
      conf <= 1'b0;
    end else begin
      conf <= (cnt >= len - 1'b1);
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rg_classify.sv
// Chooses phase isolation or global shutdown for confirmed faults.
module rg_classify #(
  parameter int NPH = 4,
  parameter int PW  = 3
) (
  input  logic [NPH-1:0] ph_flt,
  input  logic           uv_flt,
  input  logic [NPH-1:0] mask,
  input  logic           iso_en,
  input  logic           lock_mode,
  input  logic [PW-1:0]  min_ph,
  output logic           glob,
  output logic           busy,
  output logic [NPH-1:0] iso_sel
);
  logic [NPH-1:0] fresh;
  logic           can_iso;
  int             nfresh;
  int             nleft;

  always_comb begin
    fresh   = ph_flt & ~mask;
    nfresh  = $countones(fresh);
    nleft   = NPH - $countones(mask) - 1;
    can_iso = iso_en && !lock_mode && !uv_flt && (nfresh == 1) &&
              (nleft >= int'(min_ph));
    iso_sel = can_iso ? fresh : '0;
    glob    = uv_flt || ((nfresh != 0) && !can_iso);
    busy    = uv_flt || (nfresh != 0);
  end
endmodule

// File: rtl/rg_recovery.sv
// Rail state machine: hold, cooldown, bounded retry, lock-off.
module rg_recovery
  import rg_pkg::*;
#(
  parameter int TW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          glob,
  input  logic          busy,
  input  logic          uv_ok,
  input  logic          lock_mode,
  input  logic          clear,
  input  logic [TW-1:0] cool_len,
  input  logic [TW-1:0] win_len,
  input  logic [CW-1:0] cap,
  output rg_state_e     state,
  output logic          tripped
);
  logic [TW-1:0] ccnt;
  logic [TW-1:0] wcnt;
  logic [CW-1:0] retries;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HOLD;
      tripped <= 1'b0;
      ccnt    <= '0;
      wcnt    <= '0;
      retries <= '0;
    end else begin
      // observation window: forget retries after a quiet span
      if (retries != '0) begin
        if (wcnt >= win_len) begin
          retries <= '0;
          wcnt    <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
      if (clear) begin
        retries <= '0;
        wcnt    <= '0;
      end
      case (state)
        ST_RUN: if (glob) begin
          tripped <= 1'b1;
          wcnt    <= '0;
          if (lock_mode || retries >= cap) begin
            state <= ST_LOCK;
          end else begin
            state <= ST_HOLD;
            if (retries != '1) retries <= retries + 1'b1;
          end
        end
        ST_HOLD: if (!busy && uv_ok) begin
          state <= ST_COOL;
          ccnt  <= '0;
        end
        ST_COOL: begin
          if (busy) begin
            state <= ST_HOLD;
          end else if (ccnt >= cool_len) begin
            state   <= ST_RUN;
            tripped <= 1'b0;
          end else begin
            ccnt <= ccnt + 1'b1;
          end
        end
        default: if (clear) state <= ST_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/rail_guard.sv
module rail_guard
  import rg_pkg::*;
#(
  parameter int NPH = 4,
  parameter int TW  = 16,
  parameter int CW  = 4,
  localparam int PW = $clog2(NPH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] oc_flag,
  input  logic [NPH-1:0] ot_flag,
  input  logic           uv_low,
  input  logic           uv_high,
  input  logic           lock_mode,
  input  logic           iso_en,
  input  logic [PW-1:0]  min_ph,
  input  logic [TW-1:0]  deb_len,
  input  logic [TW-1:0]  cool_len,
  input  logic [TW-1:0]  win_len,
  input  logic [TW-1:0]  pg_len,
  input  logic [TW-1:0]  uv_len,
  input  logic [CW-1:0]  retry_cap,
  input  logic           clear,
  output logic [NPH-1:0] phase_off,
  output logic           rail_off,
  output logic           fault,
  output logic           pgood,
  output logic           hot,
  output logic           locked
);
  logic [NPH-1:0] oc_c, ot_c, iso_mask, iso_sel;
  logic           uv_c, glob, busy, tripped, uv_ok;
  logic [TW-1:0]  uv_cnt, pg_cnt;
  rg_state_e      state;

  // detect
  for (genvar i = 0; i < NPH; i++) begin : g_ph
    rg_filter #(.TW(TW)) u_oc (.clk(clk), .rst(rst), .raw(oc_flag[i]), .len(deb_len), .conf(oc_c[i]));
    rg_filter #(.TW(TW)) u_ot (.clk(clk), .rst(rst), .raw(ot_flag[i]), .len(deb_len), .conf(ot_c[i]));
  end
  rg_filter #(.TW(TW)) u_uv (.clk(clk), .rst(rst), .raw(uv_low), .len(deb_len), .conf(uv_c));

  // classify
  rg_classify #(.NPH(NPH), .PW(PW)) u_cls (
    .ph_flt(oc_c | ot_c), .uv_flt(uv_c), .mask(iso_mask), .iso_en(iso_en),
    .lock_mode(lock_mode), .min_ph(min_ph), .glob(glob), .busy(busy), .iso_sel(iso_sel)
  );

  // recover
  rg_recovery #(.TW(TW), .CW(CW)) u_rec (
    .clk(clk), .rst(rst), .glob(glob), .busy(busy), .uv_ok(uv_ok),
    .lock_mode(lock_mode), .clear(clear), .cool_len(cool_len), .win_len(win_len),
    .cap(retry_cap), .state(state), .tripped(tripped)
  );

  // supply stability above the turn-on level
  assign uv_ok = (uv_cnt >= uv_len);
  always_ff @(posedge clk) begin
    if (rst || !uv_high || uv_low) uv_cnt <= '0;
    else if (!uv_ok)               uv_cnt <= uv_cnt + 1'b1;
  end

  // act: inhibit follows the confirmed fault in the same cycle
  assign rail_off  = (state != ST_RUN) || glob;
  assign phase_off = iso_mask | iso_sel | {NPH{rail_off}};
  assign locked    = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst || clear)         iso_mask <= '0;
    else if (state == ST_RUN) iso_mask <= iso_mask | iso_sel;
  end

  // report: one cycle behind the inhibit
  always_ff @(posedge clk) begin
    if (rst) begin
      fault  <= 1'b0;
      hot    <= 1'b0;
      pgood  <= 1'b0;
      pg_cnt <= '0;
    end else begin
      fault <= glob || (|iso_sel) || (|iso_mask) || tripped;
      hot   <= |ot_c;
      if (rail_off) begin
        pgood  <= 1'b0;
        pg_cnt <= '0;
      end else if (pg_cnt >= pg_len) begin
        pgood <= 1'b1;
      end else begin
        pg_cnt <= pg_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rail_guard_chk.sv
module rail_guard_chk #(
  parameter int NPH = 4,
  parameter int TW  = 16,
  parameter int PW  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           uv_low,
  input logic           clear,
  input logic [TW-1:0]  deb_len,
  input logic [PW-1:0]  min_ph,
  input logic [NPH-1:0] phase_off,
  input logic           rail_off,
  input logic           fault,
  input logic           pgood,
  input logic           locked
);
  logic [TW-1:0] uv_run;

  always_ff @(posedge clk) begin
    if (rst || !uv_low)  uv_run <= '0;
    else if (uv_run != '1) uv_run <= uv_run + 1'b1;
  end

  p_uv_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (deb_len != '0 && uv_run >= deb_len) |-> rail_off);

  p_report_order_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(rail_off || (phase_off != '0)));

  p_pgood_drop_r10: assert property (@(posedge clk) disable iff (rst)
    rail_off |=> !pgood);

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (locked && !clear) |=> (locked && rail_off));

  p_iso_limit_r2: assert property (@(posedge clk) disable iff (rst)
    !rail_off |-> ($countones(phase_off) <= NPH - int'(min_ph)));
endmodule

bind rail_guard rail_guard_chk #(.NPH(NPH), .TW(TW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .uv_low(uv_low), .clear(clear), .deb_len(deb_len),
  .min_ph(min_ph), .phase_off(phase_off), .rail_off(rail_off), .fault(fault),
  .pgood(pgood), .locked(locked)
);

// File: tb/rail_guard_tb.sv
`timescale 1ns/1ps
module rail_guard_tb;
  localparam int NPH = 4, TW = 16, CW = 4, PW = 3;
  localparam int DEB = 3, COOL = 10, WIN = 100, PG = 5, UVS = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [NPH-1:0] oc_flag = '0, ot_flag = '0, phase_off;
  logic uv_low = 1'b0, uv_high = 1'b1, lock_mode = 1'b0, iso_en = 1'b1, clear = 1'b0;
  logic rail_off, fault, pgood, hot, locked;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rail_guard #(.NPH(NPH), .TW(TW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .oc_flag(oc_flag), .ot_flag(ot_flag), .uv_low(uv_low),
    .uv_high(uv_high), .lock_mode(lock_mode), .iso_en(iso_en), .min_ph(3'd3),
    .deb_len(16'(DEB)), .cool_len(16'(COOL)), .win_len(16'(WIN)), .pg_len(16'(PG)),
    .uv_len(16'(UVS)), .retry_cap(4'd2), .clear(clear), .phase_off(phase_off),
    .rail_off(rail_off), .fault(fault), .pgood(pgood), .hot(hot), .locked(locked)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wait_rail(output int n);
    n = 0;
    while (rail_off && n < 1000) begin step(1); n++; end
  endtask

  task automatic wait_pg(output int n);
    n = 0;
    while (!pgood && n < 1000) begin step(1); n++; end
  endtask

  task automatic pulse_clear();
    clear = 1'b1; step(1); clear = 1'b0; step(1);
  endtask

  // two phases at once: a global fault, one retry event
  task automatic glob_event(input bit wait_on);
    int n;
    oc_flag = 4'b0110; step(DEB + 2); oc_flag = '0;
    if (wait_on) wait_rail(n);
  endtask

  task automatic t_reset();
    int n;
    step(3);
    chk("R4", "reset rail_off", rail_off, 1);
    chk("R10", "reset pgood", pgood, 0);
    chk("R4", "reset fault", fault, 0);
    chk("R5", "reset locked", locked, 0);
    rst = 1'b0;
    wait_rail(n);
    chk_rng("R9", "startup supply wait", n, UVS + COOL, UVS + COOL + 4);
    wait_pg(n);
    chk("R10", "pgood delay", n, PG + 1);
  endtask

  task automatic t_glitch();
    oc_flag[1] = 1'b1; step(DEB - 1); oc_flag[1] = 1'b0; step(3);
    chk("R1", "glitch phase_off", phase_off, 0);
    chk("R1", "glitch fault", fault, 0);
    chk("R1", "glitch pgood", pgood, 1);
  endtask

  task automatic t_isolate();
    oc_flag[2] = 1'b1; step(DEB - 1);
    chk("R1", "before debounce", phase_off, 0);
    step(1);
    chk("R2", "isolated mask", phase_off, 4'b0100);
    chk("R2", "rail kept on", rail_off, 0);
    chk("R4", "fault not yet", fault, 0);
    step(1);
    chk("R4", "fault after one cycle", fault, 1);
    chk("R2", "pgood kept", pgood, 1);
    oc_flag[2] = 1'b0; step(5);
    chk("R2", "isolation held", phase_off, 4'b0100);
    pulse_clear(); step(1);
    chk("R2", "clear releases phase", phase_off, 0);
    chk("R2", "clear drops fault", fault, 0);
  endtask

  task automatic t_global();
    int n;
    oc_flag[0] = 1'b1; ot_flag[3] = 1'b1; step(DEB);
    chk("R3", "two phases global", rail_off, 1);
    chk("R3", "all phases off", phase_off, 4'hF);
    chk("R4", "pgood same cycle", pgood, 1);
    step(1);
    chk("R4", "pgood falls next", pgood, 0);
    chk("R4", "fault rises next", fault, 1);
    chk("R11", "hot reported", hot, 1);
    oc_flag = '0; ot_flag = '0; step(2);
    chk("R11", "hot clears", hot, 0);
    wait_rail(n);
    chk_rng("R6", "cooldown length", n + 2, COOL + 1, COOL + 4);
    wait_pg(n);
    chk("R10", "pgood delay after retry", n, PG + 1);
  endtask

  task automatic t_uv();
    int n;
    uv_low = 1'b1; uv_high = 1'b0; step(DEB);
    chk("R3", "undervoltage global", rail_off, 1);
    uv_low = 1'b0; step(30);
    chk("R9", "band keeps rail off", rail_off, 1);
    uv_high = 1'b1;
    wait_rail(n);
    chk_rng("R9", "supply stability wait", n, UVS + COOL, UVS + COOL + 4);
    uv_high = 1'b0; step(30);
    chk("R9", "band ignored while running", rail_off, 0);
    uv_high = 1'b1; step(2);
  endtask

  task automatic t_cap();
    step(WIN + 50);
    glob_event(1); glob_event(1);
    chk("R7", "two retries allowed", locked, 0);
    glob_event(0); step(2);
    chk("R7", "third event locks", locked, 1);
    step(50);
    chk("R5", "lock persists", rail_off, 1);
    pulse_clear();
    chk("R5", "clear unlocks", locked, 0);
    step(40);
    chk("R5", "rail back after clear", rail_off, 0);
  endtask

  task automatic t_window();
    for (int k = 0; k < 3; k++) begin
      glob_event(1); step(WIN + 50);
    end
    chk("R8", "spaced events not locked", locked, 0);
    chk("R8", "rail on", rail_off, 0);
  endtask

  task automatic t_lock();
    int n;
    lock_mode = 1'b1; oc_flag[3] = 1'b1; step(DEB);
    chk("R5", "lock mode no isolation", rail_off, 1);
    step(2);
    chk("R5", "lock mode locks", locked, 1);
    oc_flag[3] = 1'b0; step(40);
    chk("R5", "no retry in lock mode", locked, 1);
    lock_mode = 1'b0; pulse_clear();
    wait_rail(n);
    chk_rng("R6", "recover after clear", n, COOL - 2, COOL + 4);
  endtask

  task automatic t_too_few();
    int n;
    oc_flag[0] = 1'b1; step(DEB + 1);
    chk("R2", "first isolated", phase_off, 4'b0001);
    oc_flag[1] = 1'b1; step(DEB);
    chk("R3", "too few survivors global", rail_off, 1);
    oc_flag = '0; pulse_clear();
    wait_rail(n);
    chk("R3", "rail recovered", rail_off, 0);
    chk("R2", "mask cleared", phase_off, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_glitch();
    t_isolate();
    t_global();
    t_uv();
    t_cap();
    t_window();
    t_lock();
    t_too_few();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule